// File: doc/BRIEF.md
# Multi-View General Register File

This block holds sixteen 64-bit general registers and lets a datapath reach each one through narrower windows: the whole register, its low 32 bits, its low 16 bits, its lowest byte, or (for the first four registers only) the byte that sits in bits 15:8. Two read ports and one write port are provided. Each port names a register, a size code and a high-byte flag. A separate input tells the block whether the wide 64-bit operating mode is on, since some byte windows exist only in that mode.

A read returns the chosen window, zero-extended to 64 bits, in the same cycle. A write updates the register at the next clock edge. How much of the register a write touches depends on its size. Byte and 16-bit writes replace only their own bits. A 32-bit write loads the low half and clears the high half. A 64-bit write replaces everything. A port that asks for a window the register or mode does not offer raises its error output, and the request has no effect.

Top module: `gpr_file`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every register to zero.
- R2: Size code 2'b11 reads bits 63:0, 2'b10 reads bits 31:0, 2'b01 reads bits 15:0, and 2'b00 reads bits 7:0 with the high flag low or bits 15:8 with the high flag high. Every result is zero-extended to 64 bits.
- R3: A write with size 2'b00 (either byte) or 2'b01 changes only the bits of its window and keeps all other bits of the register.
- R4: A write with size 2'b10 puts the data's bits 31:0 into bits 31:0 and sets bits 63:32 to zero.
- R5: A write with size 2'b11 replaces all 64 bits.
- R6: A high-byte request is legal only for registers 0 to 3 with size 2'b00. A high flag with any other register or any other size is illegal.
- R7: The low-byte window of registers 0 to 3 is always legal. The low-byte window of registers 4 to 15 is legal only while `mode64` is high. Sizes 2'b01, 2'b10 and 2'b11 are legal for every register.
- R8: An illegal read raises that port's error output and returns zero data.
- R9: A write with `wr_en` high and an illegal request raises `wr_err` and leaves every register unchanged. With `wr_en` low, `wr_err` stays low.
- R10: A read of the register being written in the same cycle returns the value from before the write. The new value is visible after the clock edge.
- R11: The two read ports work independently and can read different registers and sizes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode64 | input | 1 | High while 64-bit mode is active |
| rd_a_idx | input | 4 | Register index, read port A |
| rd_a_size | input | 2 | Size code, read port A |
| rd_a_hi | input | 1 | High-byte select, read port A |
| rd_a_data | output | 64 | Zero-extended view, read port A |
| rd_a_err | output | 1 | Illegal request, read port A |
| rd_b_idx | input | 4 | Register index, read port B |
| rd_b_size | input | 2 | Size code, read port B |
| rd_b_hi | input | 1 | High-byte select, read port B |
| rd_b_data | output | 64 | Zero-extended view, read port B |
| rd_b_err | output | 1 | Illegal request, read port B |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register index, write port |
| wr_size | input | 2 | Size code, write port |
| wr_hi | input | 1 | High-byte select, write port |
| wr_data | input | 64 | Write data, aligned at bit 0 |
| wr_err | output | 1 | Illegal write request |

## Verification
The main test loads registers with values whose bytes are all different, such as 0x1122334455667788. Each read window and each merge then shows which byte went where, so a byte that is swapped, shifted or kept when it should be dropped gives a different value. Writes are stacked on the same register (high byte, then low byte, then 16 bits, then 32 bits), and each result depends on every earlier step. Legality is tried on both sides of each boundary: register 3 against register 4 for the high byte, registers below 4 against higher ones with `mode64` off and on, and the high flag paired with a size that is not a byte. Dual-port and same-cycle reads separate a combinational read from a registered bypass.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  localparam int GPR_XLEN = 64;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_FULL = 2'b11
  } gpr_size_e;

  // Legality of a view: hi-byte only on the first nhigh registers with byte size,
  // low byte beyond the first nlowfree registers only in 64-bit mode.
  function automatic logic view_ok(input int idx, input int nreg, input int nhigh,
                                   input int nlowfree, input logic [1:0] size,
                                   input logic hi, input logic mode64);
    if (idx >= nreg) return 1'b0;
    if (hi) return (size == SZ_BYTE) && (idx < nhigh);
    if (size == SZ_BYTE) return (idx < nlowfree) || mode64;
    return 1'b1;
  endfunction

  function automatic logic [GPR_XLEN-1:0] view_read(input logic [GPR_XLEN-1:0] w,
                                                    input logic [1:0] size,
                                                    input logic hi);
    logic [GPR_XLEN-1:0] r;
    r = '0;
    case (size)
      SZ_BYTE: r[7:0]  = hi ? w[15:8] : w[7:0];
      SZ_HALF: r[15:0] = w[15:0];
      SZ_WORD: r[31:0] = w[31:0];
      default: r       = w;
    endcase
    return r;
  endfunction

  function automatic logic [GPR_XLEN-1:0] view_write(input logic [GPR_XLEN-1:0] old,
                                                     input logic [GPR_XLEN-1:0] d,
                                                     input logic [1:0] size,
                                                     input logic hi);
    logic [GPR_XLEN-1:0] n;
    n = old;
    case (size)
      SZ_BYTE: if (hi) n[15:8] = d[7:0]; else n[7:0] = d[7:0];
      SZ_HALF: n[15:0] = d[15:0];
      SZ_WORD: n = {{(GPR_XLEN-32){1'b0}}, d[31:0]};
      default: n = d;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/gpr_view_check.sv
module gpr_view_check #(
  parameter int NREG     = 16,
  parameter int NHIGH    = 4,
  parameter int NLOWFREE = 4,
  localparam int IDX_W   = $clog2(NREG)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  input  logic             hi,
  input  logic             mode64,
  output logic             ok
);
  always_comb ok = gpr_pkg::view_ok(int'(idx), NREG, NHIGH, NLOWFREE, size, hi, mode64);
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int NREG   = 16,
  localparam int XLEN  = gpr_pkg::GPR_XLEN,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0][XLEN-1:0] file,
  input  logic [IDX_W-1:0]          idx,
  input  logic [1:0]                size,
  input  logic                      hi,
  input  logic                      ok,
  output logic [XLEN-1:0]           data
);
  logic [XLEN-1:0] sel_word;
  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == IDX_W'(i)) sel_word = file[i];
    data = ok ? gpr_pkg::view_read(sel_word, size, hi) : '0;
  end
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge #(
  localparam int XLEN = gpr_pkg::GPR_XLEN
) (
  input  logic [XLEN-1:0] old_word,
  input  logic [XLEN-1:0] wdata,
  input  logic [1:0]      size,
  input  logic            hi,
  output logic [XLEN-1:0] new_word
);
  always_comb new_word = gpr_pkg::view_write(old_word, wdata, size, hi);
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int NREG     = 16,
  parameter int NHIGH    = 4,
  parameter int NLOWFREE = 4,
  localparam int XLEN    = gpr_pkg::GPR_XLEN,
  localparam int IDX_W   = $clog2(NREG),
  localparam int NRD     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode64,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [1:0]       rd_a_size,
  input  logic             rd_a_hi,
  output logic [XLEN-1:0]  rd_a_data,
  output logic             rd_a_err,
  input  logic [IDX_W-1:0] rd_b_idx,
  input  logic [1:0]       rd_b_size,
  input  logic             rd_b_hi,
  output logic [XLEN-1:0]  rd_b_data,
  output logic             rd_b_err,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_size,
  input  logic             wr_hi,
  input  logic [XLEN-1:0]  wr_data,
  output logic             wr_err
);
  import gpr_pkg::*;

  logic [NREG-1:0][XLEN-1:0] file_q;

  // read ports gathered into arrays
  logic [NRD-1:0][IDX_W-1:0] rd_idx;
  logic [NRD-1:0][1:0]       rd_size;
  logic [NRD-1:0]            rd_hi;
  logic [NRD-1:0][XLEN-1:0]  rd_data;
  logic [NRD-1:0]            rd_ok;

  assign rd_idx  = {rd_b_idx, rd_a_idx};
  assign rd_size = {rd_b_size, rd_a_size};
  assign rd_hi   = {rd_b_hi, rd_a_hi};

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    gpr_view_check #(.NREG(NREG), .NHIGH(NHIGH), .NLOWFREE(NLOWFREE)) chk_i (
      .idx(rd_idx[p]), .size(rd_size[p]), .hi(rd_hi[p]), .mode64(mode64), .ok(rd_ok[p]));
    gpr_read_port #(.NREG(NREG)) rd_i (
      .file(file_q), .idx(rd_idx[p]), .size(rd_size[p]), .hi(rd_hi[p]),
      .ok(rd_ok[p]), .data(rd_data[p]));
  end

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];
  assign rd_a_err  = ~rd_ok[0];
  assign rd_b_err  = ~rd_ok[1];

  // write port
  logic            wr_ok;
  logic            wr_commit;
  logic            wr_reject;
  logic [XLEN-1:0] wr_old;
  logic [XLEN-1:0] wr_new;

  gpr_view_check #(.NREG(NREG), .NHIGH(NHIGH), .NLOWFREE(NLOWFREE)) wchk_i (
    .idx(wr_idx), .size(wr_size), .hi(wr_hi), .mode64(mode64), .ok(wr_ok));

  always_comb begin
    wr_old = '0;
    for (int i = 0; i < NREG; i++)
      if (wr_idx == IDX_W'(i)) wr_old = file_q[i];
  end

  gpr_write_merge merge_i (
    .old_word(wr_old), .wdata(wr_data), .size(wr_size), .hi(wr_hi), .new_word(wr_new));

  assign wr_commit = wr_en & wr_ok;
  assign wr_reject = wr_en & ~wr_ok;
  assign wr_err    = wr_reject;

  always_ff @(posedge clk) begin
    if (rst) begin
      file_q <= '0;
    end else if (wr_commit) begin
      for (int i = 0; i < NREG; i++)
        if (wr_idx == IDX_W'(i)) file_q[i] <= wr_new;
    end
  end

  // assertions
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> file_q == '0);

  p_half_keeps_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_size == SZ_HALF) |=>
      file_q[$past(wr_idx)][XLEN-1:16] == $past(wr_old[XLEN-1:16]));

  p_word_clears_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_size == SZ_WORD) |=> file_q[$past(wr_idx)][XLEN-1:32] == '0);

  p_hi_needs_low_reg_r6: assert property (@(posedge clk) disable iff (rst)
    (!rd_a_err && rd_a_hi) |-> (int'(rd_a_idx) < NHIGH && rd_a_size == SZ_BYTE));

  p_lowbyte_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_size == SZ_BYTE && !wr_hi && int'(wr_idx) >= NLOWFREE) |-> mode64);

  p_bad_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_a_err |-> rd_a_data == '0) and (rd_b_err |-> rd_b_data == '0));

  p_bad_write_keeps_file_r9: assert property (@(posedge clk) disable iff (rst)
    wr_reject |=> $stable(file_q));

  p_write_lands_r10: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> file_q[$past(wr_idx)] == $past(wr_new));

endmodule

// File: tb/gpr_file_tb.sv
module gpr_file_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode64 = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [1:0]  rd_a_size = 2'b11, rd_b_size = 2'b11, wr_size = 2'b11;
  logic        rd_a_hi = 1'b0, rd_b_hi = 1'b0, wr_hi = 1'b0, wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_a_data, rd_b_data;
  logic        rd_a_err, rd_b_err, wr_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpr_file dut_i (
    .clk(clk), .rst(rst), .mode64(mode64),
    .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size), .rd_a_hi(rd_a_hi),
    .rd_a_data(rd_a_data), .rd_a_err(rd_a_err),
    .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size), .rd_b_hi(rd_b_hi),
    .rd_b_data(rd_b_data), .rd_b_err(rd_b_err),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_hi(wr_hi),
    .wr_data(wr_data), .wr_err(wr_err));

  typedef struct packed {
    logic [3:0]  req;
    logic        m64;
    logic        we;
    logic [3:0]  widx;
    logic [1:0]  wsz;
    logic        whi;
    logic [63:0] wd;
    logic [3:0]  ridx;
    logic [1:0]  rsz;
    logic        rhi;
    logic [63:0] exp_d;
    logic        exp_e;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    // R5 full write, read full
    '{4'd5, 1'b1, 1'b1, 4'd0, 2'b11, 1'b0, 64'h1122334455667788, 4'd0, 2'b11, 1'b0, 64'h1122334455667788, 1'b0},
    // R2 32-bit view
    '{4'd2, 1'b1, 1'b0, 4'd0, 2'b11, 1'b0, 64'h0, 4'd0, 2'b10, 1'b0, 64'h0000000055667788, 1'b0},
    // R2 16-bit view
    '{4'd2, 1'b1, 1'b0, 4'd0, 2'b11, 1'b0, 64'h0, 4'd0, 2'b01, 1'b0, 64'h0000000000007788, 1'b0},
    // R2 high byte view
    '{4'd2, 1'b1, 1'b0, 4'd0, 2'b11, 1'b0, 64'h0, 4'd0, 2'b00, 1'b1, 64'h0000000000000077, 1'b0},
    // R2 low byte view
    '{4'd2, 1'b1, 1'b0, 4'd0, 2'b11, 1'b0, 64'h0, 4'd0, 2'b00, 1'b0, 64'h0000000000000088, 1'b0},
    // R3 high byte merge
    '{4'd3, 1'b1, 1'b1, 4'd0, 2'b00, 1'b1, 64'hFFFFFFFFFFFFFFAB, 4'd0, 2'b11, 1'b0, 64'h112233445566AB88, 1'b0},
    // R3 low byte merge
    '{4'd3, 1'b1, 1'b1, 4'd0, 2'b00, 1'b0, 64'hFFFFFFFFFFFFFFCD, 4'd0, 2'b11, 1'b0, 64'h112233445566ABCD, 1'b0},
    // R3 16-bit merge
    '{4'd3, 1'b1, 1'b1, 4'd0, 2'b01, 1'b0, 64'hFFFFFFFFFFFF1234, 4'd0, 2'b11, 1'b0, 64'h1122334455661234, 1'b0},
    // R4 32-bit write clears upper half
    '{4'd4, 1'b1, 1'b1, 4'd0, 2'b10, 1'b0, 64'hAAAABBBB98765432, 4'd0, 2'b11, 1'b0, 64'h0000000098765432, 1'b0},
    // R5 fill r3
    '{4'd5, 1'b1, 1'b1, 4'd3, 2'b11, 1'b0, 64'hFFFFFFFFFFFFFFFF, 4'd3, 2'b11, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b0},
    // R6 high byte legal on r3
    '{4'd6, 1'b1, 1'b1, 4'd3, 2'b00, 1'b1, 64'h0000000000000000, 4'd3, 2'b11, 1'b0, 64'hFFFFFFFFFFFF00FF, 1'b0},
    // R7 r5 low byte legal in 64-bit mode
    '{4'd7, 1'b1, 1'b1, 4'd5, 2'b11, 1'b0, 64'h0123456789ABCDEF, 4'd5, 2'b00, 1'b0, 64'h00000000000000EF, 1'b0},
    // R8 r5 low byte read outside 64-bit mode
    '{4'd8, 1'b0, 1'b0, 4'd0, 2'b11, 1'b0, 64'h0, 4'd5, 2'b00, 1'b0, 64'h0, 1'b1},
    // R9 illegal r5 low byte write leaves r5
    '{4'd9, 1'b0, 1'b1, 4'd5, 2'b00, 1'b0, 64'h0000000000000011, 4'd5, 2'b11, 1'b0, 64'h0123456789ABCDEF, 1'b0},
    // R9 illegal high byte write on r4 leaves r4
    '{4'd9, 1'b1, 1'b1, 4'd4, 2'b00, 1'b1, 64'h0000000000000055, 4'd4, 2'b11, 1'b0, 64'h0, 1'b0},
    // R6 high byte read on r4 illegal
    '{4'd6, 1'b1, 1'b0, 4'd0, 2'b11, 1'b0, 64'h0, 4'd4, 2'b00, 1'b1, 64'h0, 1'b1},
    // R6 high flag with 16-bit size illegal
    '{4'd6, 1'b1, 1'b0, 4'd0, 2'b11, 1'b0, 64'h0, 4'd0, 2'b01, 1'b1, 64'h0, 1'b1},
    // R7 r2 low byte legal outside 64-bit mode
    '{4'd7, 1'b0, 1'b1, 4'd2, 2'b11, 1'b0, 64'h000000000000BEEF, 4'd2, 2'b00, 1'b0, 64'h00000000000000EF, 1'b0}
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic set_rd_a(input logic [3:0] i, input logic [1:0] s, input logic h);
    rd_a_idx = i; rd_a_size = s; rd_a_hi = h;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset (R1)
    repeat (2) @(negedge clk);
    rst = 1'b0;
    set_rd_a(4'd0, 2'b11, 1'b0);
    rd_b_idx = 4'd15; rd_b_size = 2'b11;
    #2;
    check("R1 reg0 after reset", rd_a_data, 64'h0);
    check("R1 reg15 after reset", rd_b_data, 64'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode64 = TBL[v].m64;
      wr_en = TBL[v].we; wr_idx = TBL[v].widx; wr_size = TBL[v].wsz;
      wr_hi = TBL[v].whi; wr_data = TBL[v].wd;
      @(negedge clk);
      wr_en = 1'b0;
      set_rd_a(TBL[v].ridx, TBL[v].rsz, TBL[v].rhi);
      #2;
      checks++;
      if (rd_a_data !== TBL[v].exp_d || rd_a_err !== TBL[v].exp_e) begin
        errors++;
        $display("FAIL vec %0d R%0d got %h/%b exp %h/%b", v, TBL[v].req,
                 rd_a_data, rd_a_err, TBL[v].exp_d, TBL[v].exp_e);
      end
    end

    // R9 wr_err flag behaviour
    @(negedge clk);
    mode64 = 1'b0;
    wr_en = 1'b1; wr_idx = 4'd9; wr_size = 2'b00; wr_hi = 1'b0; wr_data = 64'hFF;
    #2;
    check("R9 wr_err on illegal write", {63'h0, wr_err}, 64'h1);
    wr_en = 1'b0;
    #1;
    check("R9 wr_err low without wr_en", {63'h0, wr_err}, 64'h0);

    // R10 read during write sees old value
    @(negedge clk);
    mode64 = 1'b1;
    wr_en = 1'b1; wr_idx = 4'd7; wr_size = 2'b11; wr_hi = 1'b0; wr_data = 64'h5555AAAA5555AAAA;
    set_rd_a(4'd7, 2'b11, 1'b0);
    #2;
    check("R10 same-cycle read old", rd_a_data, 64'h0);
    @(negedge clk);
    wr_en = 1'b0;
    #2;
    check("R10 after edge new", rd_a_data, 64'h5555AAAA5555AAAA);

    // R11 both ports at once
    set_rd_a(4'd3, 2'b00, 1'b1);
    rd_b_idx = 4'd7; rd_b_size = 2'b10; rd_b_hi = 1'b0;
    #1;
    check("R11 port A r3 hi byte", rd_a_data, 64'h0);
    check("R11 port B r7 32-bit", rd_b_data, 64'h000000005555AAAA);
    rd_b_idx = 4'd4; rd_b_hi = 1'b1; rd_b_size = 2'b00;
    #1;
    check("R8 port B illegal err", {63'h0, rd_b_err}, 64'h1);
    check("R8 port B illegal data", rd_b_data, 64'h0);

    // R1 reset again clears written registers
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    set_rd_a(4'd5, 2'b11, 1'b0);
    rd_b_idx = 4'd7; rd_b_size = 2'b11; rd_b_hi = 1'b0;
    #2;
    check("R1 reg5 cleared", rd_a_data, 64'h0);
    check("R1 reg7 cleared", rd_b_data, 64'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule